// File: doc/BRIEF.md
# Power Button Debounce Controller

This block watches one active-low push-button line and runs a two-state power state machine with the states OFF and ON. The raw button level is brought into the clock domain and then filtered. A press counts only once it has stayed asserted for a selectable window. A 2-bit field picks that window from four settings, and the same setting applies to both transitions.

In OFF, an accepted press moves the machine to ON and raises the power-enable output. In ON, an accepted press does not remove power. It sets a sticky power-off interrupt request, and software clears that request with a one-cycle pulse on the clear input. Only reset returns the machine to OFF.

The millisecond length is derived from a clock-frequency parameter. A second parameter divides that length so that a simulation can reach the long windows in a few thousand cycles.

Top module: `pwr_button_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the power-enable output and the interrupt output are both low, and the machine is in OFF.
- R2: The window code selects 0, 50, 100 or 500 ms for codes 00, 01, 10 and 11. With W = ms × ticks-per-ms clock cycles, a press is accepted once the synchronized button has been asserted for W+1 consecutive samples. The resulting output change appears one clock after that sample.
- R3: The button passes through a two-flop synchronizer. With the 0 ms code, power-enable rises on the third rising edge after the button goes low, and not before.
- R4: In OFF, an accepted press sets power-enable high.
- R5: A release before acceptance restarts the count from zero, and the state does not change. Two short presses do not add up.
- R6: In ON, an accepted press sets the interrupt output. The output stays high until it is cleared.
- R7: A press produces at most one acceptance. The press that turns the power on raises no interrupt. Holding the button after a clear does not set the interrupt again; the button must be released first.
- R8: A clear pulse lowers the interrupt output on the next edge. If a clear and a new acceptance fall in the same cycle, the interrupt is set.
- R9: One window setting governs both transitions. In ON, a press shorter than the window raises no interrupt.
- R10: Once in ON, power-enable stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n_i | input | 1 | Raw push-button level, low while pressed |
| dbnc_sel_i | input | 2 | Debounce window code |
| irq_clr_i | input | 1 | One-cycle clear of the power-off interrupt |
| pwr_en_o | output | 1 | Power enable, high in ON |
| pwroff_irq_o | output | 1 | Sticky power-off interrupt request |

## Verification
The bench builds the block with a 100 MHz clock-frequency parameter and a scale divisor of 25000, which gives 4 cycles per millisecond. With these values the 50, 100 and 500 ms windows last 200, 400 and 2000 cycles. Every code can therefore be timed to its exact edge, including the slowest one. The short window also makes it cheap to test the same-cycle clear and accept collision and the exact synchronizer latency.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic {
    PWR_OFF = 1'b0,
    PWR_ON  = 1'b1
  } pwr_state_e;

  // Window length in milliseconds for each 2-bit code.
  function automatic int unsigned dbnc_ms(input logic [1:0] code);
    case (code)
      2'b00:   return 0;
      2'b01:   return 50;
      2'b10:   return 100;
      default: return 500;
    endcase
  endfunction

  // Window length in clock cycles.
  function automatic int unsigned dbnc_cycles(input logic [1:0] code,
                                              input int unsigned ticks_per_ms);
    return dbnc_ms(code) * ticks_per_ms;
  endfunction

endpackage

// File: rtl/pbc_sync.sv
module pbc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pbc_debounce.sv
module pbc_debounce #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pressed_i,
  input  logic [CW-1:0] limit_i,
  output logic          press_evt_o
);
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          reached;

  assign reached     = pressed_i && (cnt_q >= limit_i);
  assign press_evt_o = reached && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!pressed_i) begin
      cnt_q  <= '0;      // release restarts the window
      done_q <= 1'b0;
    end else begin
      if (cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
      if (reached)         done_q <= 1'b1;
    end
  end

  // R5: a released button leaves a zero count behind
  p_release_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pressed_i |=> (cnt_q == '0));

  // R7: a held button yields one event only
  p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    press_evt_o |=> !press_evt_o);
endmodule

// File: rtl/pwr_button_ctrl.sv
module pwr_button_ctrl #(
  parameter int unsigned CLK_HZ      = 24_000_000,
  parameter int unsigned MS_SCALE    = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_n_i,
  input  logic [1:0] dbnc_sel_i,
  input  logic       irq_clr_i,
  output logic       pwr_en_o,
  output logic       pwroff_irq_o
);
  import pbc_pkg::*;

  localparam int unsigned RAW_TPM   = CLK_HZ / 1000 / MS_SCALE;
  localparam int unsigned TPM       = (RAW_TPM < 1) ? 1 : RAW_TPM;
  localparam int unsigned MAX_LIMIT = 500 * TPM;
  localparam int unsigned CW        = $clog2(MAX_LIMIT + 1);

  logic          pressed;
  logic [CW-1:0] limit;
  logic          press_evt;
  logic          irq_set_evt;
  pwr_state_e    state_q;
  logic          irq_q;

  assign limit = CW'(dbnc_cycles(dbnc_sel_i, TPM));

  pbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (~btn_n_i),
    .sync_o  (pressed)
  );

  pbc_debounce #(.CW(CW)) u_dbnc (
    .clk         (clk),
    .rst_n       (rst_n),
    .pressed_i   (pressed),
    .limit_i     (limit),
    .press_evt_o (press_evt)
  );

  assign irq_set_evt = press_evt && (state_q == PWR_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_OFF;
      irq_q   <= 1'b0;
    end else begin
      if (press_evt) state_q <= PWR_ON;
      if (irq_set_evt)    irq_q <= 1'b1;   // set wins over clear
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign pwr_en_o     = (state_q == PWR_ON);
  assign pwroff_irq_o = irq_q;

  // R10: ON is left only through reset
  p_on_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en_o |=> pwr_en_o);

  // R4: power comes up only after an accepted press
  p_power_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en_o) |-> $past(press_evt));

  // R6: the request exists only with power on
  p_irq_needs_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwroff_irq_o |-> pwr_en_o);

  // R7: every rise of the request follows an accepted press
  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwroff_irq_o) |-> $past(press_evt));

  // R8: a clear with no competing event lowers the request
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_i && !irq_set_evt) |=> !pwroff_irq_o);
endmodule

// File: tb/sim_pwr_button_ctrl.sv
module sim_pwr_button_ctrl;
  localparam int CLK_HZ   = 100_000_000;
  localparam int MS_SCALE = 25_000;
  localparam int TPM      = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn_n = 1'b1;
  logic       clr = 1'b0;
  logic [1:0] sel = 2'b00;
  wire        pwr_en;
  wire        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwr_button_ctrl #(.CLK_HZ(CLK_HZ), .MS_SCALE(MS_SCALE)) u0 (
    .clk(clk), .rst_n(rst_n), .btn_n_i(btn_n), .dbnc_sel_i(sel),
    .irq_clr_i(clr), .pwr_en_o(pwr_en), .pwroff_irq_o(irq)
  );

  // Reference model: window cycles from the R2 table
  function automatic int win(input logic [1:0] s);
    return (s == 2'd0) ? 0 : (s == 2'd1) ? 50 * TPM :
           (s == 2'd2) ? 100 * TPM : 500 * TPM;
  endfunction

  bit m_s1, m_s2, m_done, m_on, m_irq;
  int m_cnt;
  bit m_acc, m_fire;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_done = 0; m_on = 0; m_irq = 0; m_cnt = 0;
    end else begin
      m_acc  = m_s2 && (m_cnt >= win(sel));
      m_fire = m_acc && !m_done;
      if (!m_s2) begin
        m_cnt = 0; m_done = 0;
      end else begin
        if (m_cnt < win(sel)) m_cnt++;
        if (m_acc) m_done = 1;
      end
      if (m_fire && m_on) m_irq = 1;
      else if (clr)       m_irq = 0;
      if (m_fire) m_on = 1;
      m_s2 = m_s1;
      m_s1 = !btn_n;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4 model power-enable", pwr_en, m_on);
      check("R6 model interrupt", irq, m_irq);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog expired: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R1 reset power-enable", pwr_en, 1'b0);
    check("R1 reset interrupt", irq, 1'b0);
    rst_n = 1'b1;
    tick(2);
    check("R1 after reset power-enable", pwr_en, 1'b0);

    // R5: two short presses at 50 ms do not add up
    sel = 2'b01;
    btn_n = 1'b0; tick(150); btn_n = 1'b1; tick(5);
    check("R5 short press one", pwr_en, 1'b0);
    btn_n = 1'b0; tick(150); btn_n = 1'b1; tick(5);
    check("R5 short press two", pwr_en, 1'b0);

    // R2/R4: exact acceptance edge at 50 ms (200 cycles)
    btn_n = 1'b0; tick(202);
    check("R2 50ms one edge early", pwr_en, 1'b0);
    tick(1);
    check("R4 power up at 50ms edge", pwr_en, 1'b1);
    tick(50);
    check("R7 power-up press raises no interrupt", irq, 1'b0);
    btn_n = 1'b1; tick(10);
    check("R7 after release", irq, 1'b0);

    // R9: short press in ON at 100 ms
    sel = 2'b10;
    btn_n = 1'b0; tick(300); btn_n = 1'b1; tick(5);
    check("R9 short press in ON", irq, 1'b0);

    // R2/R6: exact edge at 100 ms (400 cycles)
    btn_n = 1'b0; tick(402);
    check("R2 100ms one edge early", irq, 1'b0);
    tick(1);
    check("R6 interrupt at 100ms edge", irq, 1'b1);
    tick(100);
    check("R6 interrupt sticky", irq, 1'b1);
    clr = 1'b1; tick(1); clr = 1'b0;
    check("R8 clear lowers interrupt", irq, 1'b0);
    tick(600);
    check("R7 held press does not re-set", irq, 1'b0);
    btn_n = 1'b1; tick(5);

    // R2: 500 ms (2000 cycles)
    sel = 2'b11;
    btn_n = 1'b0; tick(2002);
    check("R2 500ms one edge early", irq, 1'b0);
    tick(1);
    check("R2 interrupt at 500ms edge", irq, 1'b1);
    btn_n = 1'b1; tick(5);
    clr = 1'b1; tick(1); clr = 1'b0;
    check("R8 clear again", irq, 1'b0);

    // R8: clear and acceptance in the same cycle, 0 ms
    sel = 2'b00;
    btn_n = 1'b0; tick(2);
    clr = 1'b1; tick(1); clr = 1'b0;
    check("R8 set wins over clear", irq, 1'b1);
    btn_n = 1'b1; tick(5);
    check("R10 power stays on", pwr_en, 1'b1);

    // R1: reset from ON
    rst_n = 1'b0; tick(2);
    check("R1 reset from ON power-enable", pwr_en, 1'b0);
    check("R1 reset from ON interrupt", irq, 1'b0);
    rst_n = 1'b1; tick(3);

    // R3: synchronizer latency with the 0 ms code
    btn_n = 1'b0; tick(2);
    check("R3 two edges after press", pwr_en, 1'b0);
    tick(1);
    check("R3 third edge after press", pwr_en, 1'b1);
    btn_n = 1'b1; tick(5);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule